// File: doc/BRIEF.md
# Region Wait-State Controller

This block sits between two bus requesters, a processor and a DMA engine, and the memory and peripheral regions they address. For every access it works out which region is targeted, how many wait cycles that region needs for the given direction and requester, and whether a ready input may stretch it. It then returns a one-cycle ready pulse to the requester. A DMA access to a region it must not touch, and any access to an unmapped slot, is refused with a one-cycle error and no ready.

A requester raises its request with address, write strobe and (for the processor) a sequential-access hint. It holds them until it sees ready or error. The external-bus and flash wait counts come in as programmed values and are clamped to their legal minimums. The processor and DMA may run accesses in parallel, except on the external bus. There a simultaneous request goes to the processor, and the requester that had to wait pays one arbitration cycle.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After a synchronous reset and with no request, `cpu_rdy`, `cpu_err`, `dma_rdy` and `dma_err` are all low.
- R2: Accesses to the small RAM, the large RAM and peripheral group A complete with zero waits for reads and writes from either requester, with ready in the request cycle.
- R3: Peripheral group A and group B accesses are held past their base wait count for as long as `prdy` is low.
- R4: Peripheral group C writes take 0 waits and reads take 2 waits, and `prdy` has no effect on them.
- R5: Peripheral group B reads take 2 waits and writes take 0 waits. A group B write whose request is accepted in the cycle right after the processor's previous group B write completed takes 1 extra wait.
- R6: A DMA request to peripheral group B or C, the one-time-programmable region, flash, the password window or boot ROM raises `dma_err` for one cycle in the request cycle and never raises `dma_rdy`.
- R7: Address decode uses the top 4 address bits: 0 small RAM, 1 group A, 2 group B, 3 group C, 4 large RAM, 8 to 11 external bus, 12 one-time-programmable, 13 flash, 15 boot ROM. The last 8 addresses of slot 13 form the password window. Slots 5, 6, 7 and 14 are unmapped, and a request there from either requester raises that requester's error in the request cycle.
- R8: External-bus accesses take max(`xb_wait`, 1) waits and are held further while `xrdy` is low.
- R9: An external-bus write with `wbuf_en` high and `wbuf_full` low takes 0 waits regardless of `xb_wait` and `xrdy`.
- R10: When both requesters ask for the external bus, at most one holds it. On a same-cycle tie the processor goes first. A requester that was held off starts only after the other finishes and then adds 1 wait.
- R11: The flash paged count is max(`fl_page_wait`, 1) and the random count is max(`fl_rand_wait`, paged count). `cpu_seq` high selects the paged count, and the one-time-programmable region always uses the random count.
- R12: The password window always takes 16 waits and boot ROM always takes 1 wait, whatever the programmed counts.
- R13: With N waits, ready is raised exactly N cycles after the cycle in which the request is accepted, and each requester has at most one access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until ready or error |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | AW | Processor address |
| cpu_seq | input | 1 | Processor access is sequential within a flash page |
| cpu_rdy | output | 1 | Processor access complete |
| cpu_err | output | 1 | Processor access refused |
| dma_req | input | 1 | DMA request, held until ready or error |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW | DMA address |
| dma_rdy | output | 1 | DMA access complete |
| dma_err | output | 1 | DMA access refused |
| xb_wait | input | PW | Programmed external-bus wait count |
| fl_page_wait | input | PW | Programmed flash paged wait count |
| fl_rand_wait | input | PW | Programmed flash random wait count |
| wbuf_en | input | 1 | External write buffer enabled |
| wbuf_full | input | 1 | External write buffer full |
| xrdy | input | 1 | External-bus ready |
| prdy | input | 1 | Peripheral ready |

## Verification
Two things can land in the same cycle: the external-bus tie between the processor and the DMA, and the hand-over where one requester's completion frees the bus for the other. The bench starts both requesters on the external bus at one falling edge. With a programmed count of 3, the processor must answer 3 cycles after its request. The DMA must answer 8 cycles after its own request: it waits out the processor's 4 busy cycles, then takes 3 waits plus 1 arbitration wait. A parallel pair on separate RAMs, answered in the same cycle with zero waits, shows that regions other than the external bus are not serialised.

// File: rtl/bus_wait_pkg.sv
package bus_wait_pkg;

    localparam int NUM_REQ   = 2;
    localparam int REQ_CPU   = 0;
    localparam int REQ_DMA   = 1;
    localparam int SLOT_W    = 4;
    localparam int PWD_WORDS = 8;
    localparam int PWD_WAITS = 16;
    localparam int BROM_WAITS = 1;
    localparam int PERI_READ_WAITS = 2;

    typedef enum logic [3:0] {
        RG_NONE, RG_SRAM, RG_PERA, RG_PERB, RG_PERC, RG_LRAM,
        RG_XBUS, RG_OTP, RG_FLASH, RG_PWD, RG_BROM
    } region_e;

    typedef enum logic [1:0] {
        HOLD_NONE, HOLD_PERI, HOLD_XBUS
    } hold_e;

    typedef struct packed {
        region_e region;
        logic    we;
    } acc_t;

    function automatic region_e slot_region(input logic [SLOT_W-1:0] slot);
        case (slot)
            4'd0:                 return RG_SRAM;
            4'd1:                 return RG_PERA;
            4'd2:                 return RG_PERB;
            4'd3:                 return RG_PERC;
            4'd4:                 return RG_LRAM;
            4'd8, 4'd9, 4'd10, 4'd11: return RG_XBUS;
            4'd12:                return RG_OTP;
            4'd13:                return RG_FLASH;
            4'd15:                return RG_BROM;
            default:              return RG_NONE;
        endcase
    endfunction

    function automatic logic dma_barred(input region_e r);
        return (r == RG_PERB) || (r == RG_PERC) || (r == RG_OTP) ||
               (r == RG_FLASH) || (r == RG_PWD) || (r == RG_BROM);
    endfunction

    function automatic logic hold_ok(input hold_e h, input logic prdy, input logic xrdy);
        case (h)
            HOLD_PERI: return prdy;
            HOLD_XBUS: return xrdy;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/bus_wait_plan.sv
module bus_wait_plan
    import bus_wait_pkg::*;
#(
    parameter int AW     = 16,
    parameter int PW     = 4,
    parameter int CW     = 6,
    parameter bit IS_DMA = 1'b0
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          seq,
    input  logic [PW-1:0] xb_wait,
    input  logic [PW-1:0] fl_page_wait,
    input  logic [PW-1:0] fl_rand_wait,
    input  logic          wbuf_en,
    input  logic          wbuf_full,
    input  logic          held,
    input  logic          b2b,
    output region_e       region,
    output logic          deny,
    output logic [CW-1:0] waits,
    output hold_e         hold
);
    localparam int LOW_W = AW - SLOT_W;
    localparam logic [LOW_W-1:0] PWD_START = LOW_W'((1 << LOW_W) - PWD_WORDS);

    logic [SLOT_W-1:0] slot;
    logic [LOW_W-1:0]  low;
    logic [CW-1:0]     xb_eff, pg_eff, rd_eff, rd_raw, base;

    assign slot = addr[AW-1 -: SLOT_W];
    assign low  = addr[LOW_W-1:0];

    always_comb begin
        region = slot_region(slot);
        if (region == RG_FLASH && low >= PWD_START) begin
            region = RG_PWD;
        end
    end

    assign deny = (region == RG_NONE) || (IS_DMA && dma_barred(region));

    always_comb begin
        xb_eff = (xb_wait == '0) ? CW'(1) : CW'(xb_wait);
        pg_eff = (fl_page_wait == '0) ? CW'(1) : CW'(fl_page_wait);
        rd_raw = CW'(fl_rand_wait);
        rd_eff = (rd_raw < pg_eff) ? pg_eff : rd_raw;
    end

    always_comb begin
        base = '0;
        hold = HOLD_NONE;
        case (region)
            RG_PERA: hold = HOLD_PERI;
            RG_PERB: begin
                base = we ? CW'(b2b) : CW'(PERI_READ_WAITS);
                hold = HOLD_PERI;
            end
            RG_PERC:  base = we ? '0 : CW'(PERI_READ_WAITS);
            RG_XBUS: begin
                if (!(we && wbuf_en && !wbuf_full)) begin
                    base = xb_eff;
                    hold = HOLD_XBUS;
                end
            end
            RG_OTP:   base = rd_eff;
            RG_FLASH: base = seq ? pg_eff : rd_eff;
            RG_PWD:   base = CW'(PWD_WAITS);
            RG_BROM:  base = CW'(BROM_WAITS);
            default:  base = '0;
        endcase
    end

    assign waits = base + CW'(held);

endmodule

// File: rtl/bus_wait_chan.sv
module bus_wait_chan
    import bus_wait_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  acc_t          acc_in,
    input  logic [CW-1:0] waits,
    input  hold_e         hold_in,
    input  logic          prdy,
    input  logic          xrdy,
    output logic          done,
    output logic          busy,
    output acc_t          acc_cur
);
    logic          busy_q;
    logic [CW-1:0] cnt_q;
    hold_e         hold_q;
    acc_t          acc_q;

    assign busy    = busy_q;
    assign acc_cur = busy_q ? acc_q : acc_in;

    always_comb begin
        if (busy_q) begin
            done = (cnt_q == '0) && hold_ok(hold_q, prdy, xrdy);
        end else begin
            done = start && (waits == '0) && hold_ok(hold_in, prdy, xrdy);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            hold_q <= HOLD_NONE;
            acc_q  <= '0;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start && !done) begin
            busy_q <= 1'b1;
            cnt_q  <= (waits == '0) ? '0 : waits - 1'b1;
            hold_q <= hold_in;
            acc_q  <= acc_in;
        end
    end

    a_r13_count_down: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    a_r13_no_early_ready: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |-> !done);

    a_r4_fixed_never_stretched: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == '0 && hold_q == HOLD_NONE) |-> done);

    a_r13_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy_q);

endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bus_wait_pkg::*;
#(
    parameter int AW = 16,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_seq,
    output logic          cpu_rdy,
    output logic          cpu_err,
    input  logic          dma_req,
    input  logic          dma_we,
    input  logic [AW-1:0] dma_addr,
    output logic          dma_rdy,
    output logic          dma_err,
    input  logic [PW-1:0] xb_wait,
    input  logic [PW-1:0] fl_page_wait,
    input  logic [PW-1:0] fl_rand_wait,
    input  logic          wbuf_en,
    input  logic          wbuf_full,
    input  logic          xrdy,
    input  logic          prdy
);
    localparam int CW = PW + 2;

    logic [NUM_REQ-1:0] req_v, we_v, seq_v, busy_v, done_v, deny_v;
    logic [NUM_REQ-1:0] want_ext, lose_v, start_v, err_v, held_v, b2b_v, ext_busy;
    logic [AW-1:0]      addr_a [NUM_REQ];
    region_e            reg_a  [NUM_REQ];
    acc_t               cur_a  [NUM_REQ];

    assign req_v = {dma_req, cpu_req};
    assign we_v  = {dma_we, cpu_we};
    assign seq_v = {1'b0, cpu_seq};
    assign addr_a[REQ_CPU] = cpu_addr;
    assign addr_a[REQ_DMA] = dma_addr;

    // The processor wins a same-cycle tie on the external bus.
    assign lose_v[REQ_CPU] = want_ext[REQ_CPU] && ext_busy[REQ_DMA];
    assign lose_v[REQ_DMA] = want_ext[REQ_DMA] && (ext_busy[REQ_CPU] || want_ext[REQ_CPU]);

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
            logic [CW-1:0] waits;
            hold_e         hold;
            acc_t          acc_in;
            logic          held_r, b2b_r;

            bus_wait_plan #(
                .AW(AW), .PW(PW), .CW(CW), .IS_DMA(g == REQ_DMA)
            ) u_plan (
                .addr(addr_a[g]), .we(we_v[g]), .seq(seq_v[g]),
                .xb_wait(xb_wait), .fl_page_wait(fl_page_wait),
                .fl_rand_wait(fl_rand_wait), .wbuf_en(wbuf_en),
                .wbuf_full(wbuf_full), .held(held_r), .b2b(b2b_r),
                .region(reg_a[g]), .deny(deny_v[g]), .waits(waits), .hold(hold)
            );

            assign acc_in = '{region: reg_a[g], we: we_v[g]};

            bus_wait_chan #(.CW(CW)) u_chan (
                .clk(clk), .rst(rst), .start(start_v[g]), .acc_in(acc_in),
                .waits(waits), .hold_in(hold), .prdy(prdy), .xrdy(xrdy),
                .done(done_v[g]), .busy(busy_v[g]), .acc_cur(cur_a[g])
            );

            assign want_ext[g] = !busy_v[g] && req_v[g] && !deny_v[g] && (reg_a[g] == RG_XBUS);
            assign start_v[g]  = !busy_v[g] && req_v[g] && !deny_v[g] && !lose_v[g];
            assign err_v[g]    = !busy_v[g] && req_v[g] && deny_v[g];
            assign ext_busy[g] = busy_v[g] && (cur_a[g].region == RG_XBUS);

            always_ff @(posedge clk) begin
                if (rst) begin
                    held_r <= 1'b0;
                    b2b_r  <= 1'b0;
                end else begin
                    if (lose_v[g]) begin
                        held_r <= 1'b1;
                    end else if (start_v[g] || !req_v[g]) begin
                        held_r <= 1'b0;
                    end
                    b2b_r <= done_v[g] && (cur_a[g].region == RG_PERB) && cur_a[g].we;
                end
            end

            assign held_v[g] = held_r;
            assign b2b_v[g]  = b2b_r;
        end
    endgenerate

    assign cpu_rdy = done_v[REQ_CPU];
    assign cpu_err = err_v[REQ_CPU];
    assign dma_rdy = done_v[REQ_DMA];
    assign dma_err = err_v[REQ_DMA];

    a_r10_bus_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ext_busy[REQ_CPU] && ext_busy[REQ_DMA]));

    a_r10_loser_pays: assert property (@(posedge clk) disable iff (rst)
        (held_v[REQ_DMA] && start_v[REQ_DMA]) |-> !dma_rdy);

    a_r6_dma_never_ready_barred: assert property (@(posedge clk) disable iff (rst)
        dma_rdy |-> !dma_barred(cur_a[REQ_DMA].region));

    a_r7_ready_error_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(cpu_rdy && cpu_err) && !(dma_rdy && dma_err));

    a_r5_back_to_back_extra: assert property (@(posedge clk) disable iff (rst)
        (b2b_v[REQ_CPU] && start_v[REQ_CPU] && cpu_we && reg_a[REQ_CPU] == RG_PERB) |-> !cpu_rdy);

endmodule

// File: tb/bus_wait_ctrl_test.sv
module bus_wait_ctrl_test;
    localparam int PER  = 10;
    localparam int HALF = PER / 2;
    localparam int AW   = 16;
    localparam int PW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 0, cpu_we = 0, cpu_seq = 0, dma_req = 0, dma_we = 0;
    logic [AW-1:0] cpu_addr = '0, dma_addr = '0;
    logic cpu_rdy, cpu_err, dma_rdy, dma_err;
    logic [PW-1:0] xb_wait = 4'd3, fl_page_wait = 4'd2, fl_rand_wait = 4'd4;
    logic wbuf_en = 0, wbuf_full = 0, xrdy = 1, prdy = 1;

    bus_wait_ctrl #(.AW(AW), .PW(PW)) uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_seq(cpu_seq),
        .cpu_rdy(cpu_rdy), .cpu_err(cpu_err),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr),
        .dma_rdy(dma_rdy), .dma_err(dma_err),
        .xb_wait(xb_wait), .fl_page_wait(fl_page_wait), .fl_rand_wait(fl_rand_wait),
        .wbuf_en(wbuf_en), .wbuf_full(wbuf_full), .xrdy(xrdy), .prdy(prdy)
    );

    always #HALF clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    start;
        int    lat;
        bit    err;
        string tag;
    } exp_t;

    exp_t q_cpu[$];
    exp_t q_dma[$];
    int checks = 0;
    int fails  = 0;

    task automatic report(input bit ok, input string tag, input string what,
                          input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Encoded result: latency, plus 1000 for an error, plus 5000 for ready and error together.
    task automatic judge(input exp_t e, input logic rdy, input logic err, input string who);
        int act, exp;
        act = (cyc - e.start) + (err ? 1000 : 0) + ((rdy && err) ? 5000 : 0);
        exp = e.lat + (e.err ? 1000 : 0);
        report(act == exp, e.tag, {who, " response code"}, act, exp);
    endtask

    function automatic logic [AW-1:0] at(input int slot, input int low);
        return {slot[3:0], low[AW-5:0]};
    endfunction

    // Monitor: scoreboard pop and compare, sampled just before each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #(HALF - 2);
            if (!rst) begin
                if (cpu_rdy || cpu_err) begin
                    if (q_cpu.size() == 0) report(0, "R13", "cpu unexpected response", 1, 0);
                    else begin e = q_cpu.pop_front(); judge(e, cpu_rdy, cpu_err, "cpu"); end
                end
                if (dma_rdy || dma_err) begin
                    if (q_dma.size() == 0) report(0, "R13", "dma unexpected response", 1, 0);
                    else begin e = q_dma.pop_front(); judge(e, dma_rdy, dma_err, "dma"); end
                end
            end
        end
    end

    // Driver: called at a falling edge; returns at the falling edge after the response.
    task automatic access(input int who, input logic [AW-1:0] a, input logic w,
                          input logic s, input int lat, input bit e, input string tag);
        exp_t it;
        int n;
        it.start = cyc; it.lat = lat; it.err = e; it.tag = tag;
        if (who == 0) begin
            q_cpu.push_back(it);
            cpu_req = 1; cpu_addr = a; cpu_we = w; cpu_seq = s;
        end else begin
            q_dma.push_back(it);
            dma_req = 1; dma_addr = a; dma_we = w;
        end
        n = 0;
        forever begin
            #(HALF - 2);
            if (who == 0 && (cpu_rdy || cpu_err)) break;
            if (who == 1 && (dma_rdy || dma_err)) break;
            @(negedge clk);
            n++;
            if (n > 200) begin
                report(0, tag, "access timeout", n, lat);
                if (who == 0) begin cpu_req = 0; void'(q_cpu.pop_back()); end
                else begin dma_req = 0; void'(q_dma.pop_back()); end
                return;
            end
        end
        @(negedge clk);
    endtask

    task automatic release_req(input int who);
        if (who == 0) cpu_req = 0; else dma_req = 0;
    endtask

    task automatic one(input int who, input logic [AW-1:0] a, input logic w,
                       input logic s, input int lat, input bit e, input string tag);
        access(who, a, w, s, lat, e, tag);
        release_req(who);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        report(0, "R13", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #(HALF - 2);
        report(!cpu_rdy && !cpu_err && !dma_rdy && !dma_err, "R1", "idle outputs after reset",
               {cpu_rdy, cpu_err, dma_rdy, dma_err}, 0);
        @(negedge clk);

        // R2 zero-wait regions
        one(0, at(0, 16), 0, 0, 0, 0, "R2");
        one(0, at(0, 16), 1, 0, 0, 0, "R2");
        one(0, at(4, 32), 0, 0, 0, 0, "R2");
        one(0, at(1, 8),  1, 0, 0, 0, "R2");
        one(1, at(0, 16), 0, 0, 0, 0, "R2");
        one(1, at(4, 32), 1, 0, 0, 0, "R2");
        one(1, at(1, 8),  0, 0, 0, 0, "R2");
        fork
            one(0, at(0, 4), 0, 0, 0, 0, "R2");
            one(1, at(4, 4), 0, 0, 0, 0, "R2");
        join

        // R3 peripheral stretch
        fork
            one(0, at(1, 8), 0, 0, 3, 0, "R3");
            begin prdy = 0; repeat (3) @(negedge clk); prdy = 1; end
        join
        fork
            one(0, at(2, 8), 0, 0, 4, 0, "R3");
            begin prdy = 0; repeat (4) @(negedge clk); prdy = 1; end
        join

        // R4 group C fixed, prdy ignored
        prdy = 0;
        one(0, at(3, 8), 0, 0, 2, 0, "R4");
        one(0, at(3, 8), 1, 0, 0, 0, "R4");
        prdy = 1;

        // R5 group B and back-to-back writes
        one(0, at(2, 8), 0, 0, 2, 0, "R5");
        access(0, at(2, 8), 1, 0, 0, 0, "R5");
        access(0, at(2, 12), 1, 0, 1, 0, "R5");
        release_req(0);
        @(negedge clk);
        one(0, at(2, 8), 1, 0, 0, 0, "R5");

        // R6 DMA refused regions
        one(1, at(2, 8), 1, 0, 0, 1, "R6");
        one(1, at(3, 8), 0, 0, 0, 1, "R6");
        one(1, at(12, 8), 0, 0, 0, 1, "R6");
        one(1, at(13, 8), 0, 0, 0, 1, "R6");
        one(1, at(13, 4090), 0, 0, 0, 1, "R6");
        one(1, at(15, 8), 0, 0, 0, 1, "R6");

        // R7 unmapped slots
        one(0, at(5, 0), 0, 0, 0, 1, "R7");
        one(0, at(14, 0), 1, 0, 0, 1, "R7");
        one(1, at(7, 0), 0, 0, 0, 1, "R7");

        // R8 external bus
        xb_wait = 4'd3;
        one(0, at(8, 0), 0, 0, 3, 0, "R8");
        one(1, at(9, 0), 0, 0, 3, 0, "R8");
        xb_wait = 4'd0;
        one(0, at(10, 0), 0, 0, 1, 0, "R8");
        one(0, at(10, 0), 1, 0, 1, 0, "R8");
        xb_wait = 4'd3;
        fork
            one(0, at(11, 0), 0, 0, 5, 0, "R8");
            begin xrdy = 0; repeat (5) @(negedge clk); xrdy = 1; end
        join

        // R9 buffered writes
        wbuf_en = 1;
        xrdy = 0;
        one(0, at(8, 0), 1, 0, 0, 0, "R9");
        one(1, at(8, 0), 1, 0, 0, 0, "R9");
        xrdy = 1;
        wbuf_full = 1;
        one(0, at(8, 0), 1, 0, 3, 0, "R9");
        wbuf_full = 0; wbuf_en = 0;
        one(0, at(8, 0), 1, 0, 3, 0, "R9");

        // R10 same-cycle tie on the external bus
        fork
            one(0, at(8, 0), 0, 0, 3, 0, "R10");
            one(1, at(9, 0), 0, 0, 8, 0, "R10");
        join

        // R11 flash clamps
        fl_page_wait = 4'd2; fl_rand_wait = 4'd4;
        one(0, at(13, 8), 0, 1, 2, 0, "R11");
        one(0, at(13, 8), 0, 0, 4, 0, "R11");
        one(0, at(12, 8), 0, 1, 4, 0, "R11");
        fl_page_wait = 4'd0; fl_rand_wait = 4'd0;
        one(0, at(13, 8), 0, 1, 1, 0, "R11");
        one(0, at(13, 8), 0, 0, 1, 0, "R11");
        fl_page_wait = 4'd3; fl_rand_wait = 4'd1;
        one(0, at(13, 8), 0, 0, 3, 0, "R11");

        // R12 fixed regions
        fl_page_wait = 4'd0; fl_rand_wait = 4'd0;
        one(0, at(13, 4095), 0, 0, 16, 0, "R12");
        one(0, at(13, 4088), 0, 1, 16, 0, "R12");
        one(0, at(15, 8), 0, 0, 1, 0, "R12");

        repeat (3) @(negedge clk);
        report(q_cpu.size() == 0 && q_dma.size() == 0, "R13", "responses outstanding",
               q_cpu.size() + q_dma.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule